// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a segment-relative reference (a segment register number plus a 32-bit offset) into a 32-bit linear address. It holds six 16-bit selector registers and two small on-chip descriptor tables. One table is shared by all tasks. The other belongs to the running task. A selector names one descriptor through its index field, and its table-select bit picks which table to search.

For each request the block does the following in a single combinational pass:
- decodes the selector;
- fetches the descriptor;
- adds the descriptor base to the offset;
- checks the offset against the segment limit, the privilege rings and the access type.

The result is registered one cycle later. A clean request releases the linear address. A failing request releases a fault code and a zero address.

Descriptors and selectors are loaded through simple write ports. Each write takes effect for requests issued from the following cycle on.

Top module: `seg_xlat_top`

## Requirements
- R1: A selector write with register number 0..5 stores the 16-bit value for that register. A write naming register 6 or 7 is ignored. A request naming register 6 or 7 uses the selector value 0.
- R2: Selector layout: bits 15:3 are the index, bit 2 is the table select (1 = per-task table, 0 = shared table), and bits 1:0 are the requested level. The same index reaches different descriptors in the two tables.
- R3: One cycle after a request, `out_valid` is 1. For a clean request, `out_lin` equals the descriptor base plus the offset, modulo 2^32. Cycles without a request give `out_valid` = 0.
- R4: A selector with index 0 and table select 0 is null and faults with code 1. Index 0 in the per-task table is an ordinary descriptor.
- R5: An index at or beyond the depth of the chosen table (8 shared, 4 per-task) faults with code 2. Descriptor writes beyond the depth are ignored.
- R6: With levels 0 (most privileged) to 3, access is allowed only when max(current level, requested level) <= descriptor level. Otherwise the request faults with code 3.
- R7: When the granularity bit is 0, the effective limit is the 20-bit limit. An offset above the effective limit faults with code 4.
- R8: When the granularity bit is 1, the effective limit is the 20-bit limit shifted left by 12 with ones filled into bits 11:0. An offset above it faults with code 4.
- R9: Access codes: 0 read, 1 write, 2 fetch, 3 read. A write to a descriptor without write permission, or a fetch from one without execute permission, faults with code 5. A read never takes a type fault.
- R10: When several faults apply, the lowest code wins (null, range, privilege, limit, type). Any faulted result drives `out_lin` to 0.
- R11: After reset, `out_valid` is 0, all selectors are 0, and all descriptors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Selector register write strobe |
| sel_wnum | input | 3 | Selector register number to write |
| sel_wval | input | 16 | Selector value |
| dsc_we | input | 1 | Descriptor write strobe |
| dsc_local | input | 1 | 1 writes the per-task table, 0 writes the shared table |
| dsc_widx | input | 13 | Descriptor index to write |
| dsc_base | input | 32 | Segment base |
| dsc_limit | input | 20 | Segment limit |
| dsc_gran | input | 1 | Limit granularity, 1 = 4 KB units |
| dsc_dpl | input | 2 | Descriptor privilege level |
| dsc_wrok | input | 1 | Write permitted |
| dsc_exok | input | 1 | Fetch permitted |
| req_valid | input | 1 | Translation request |
| req_seg | input | 3 | Selector register number used |
| req_off | input | 32 | Offset |
| req_acc | input | 2 | Access type |
| req_cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Result valid |
| out_lin | output | 32 | Linear address (0 on fault) |
| out_fault | output | 3 | Fault code, 0 = none |

## Verification
The privilege check and the limit check evaluate in the same cycle on the same descriptor, so one request can violate both at once. The bench provokes this with a reference from an outer ring at an offset past the limit of an inner-ring segment. It expects the privilege code, not the limit code, together with a zero address. A companion case puts a type violation behind a limit violation, so the ordering is judged at both positions.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int SEL_IDX_W = 13;

    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic        gran;
        logic [1:0]  dpl;
        logic        wr_ok;
        logic        ex_ok;
    } desc_t;

    typedef struct packed {
        logic [SEL_IDX_W-1:0] index;
        logic                 use_local;
        logic [1:0]           rpl;
    } sel_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_READ2 = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_NULL  = 3'd1,
        FLT_RANGE = 3'd2,
        FLT_PRIV  = 3'd3,
        FLT_LIMIT = 3'd4,
        FLT_TYPE  = 3'd5
    } fault_e;

    function automatic logic [31:0] eff_limit(input desc_t d);
        return d.gran ? {d.limit, 12'hFFF} : {12'h000, d.limit};
    endfunction

    function automatic logic [1:0] lvl_max(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_sel_bank.sv
module seg_sel_bank
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEGN_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEGN_W-1:0] wnum,
    input  logic [15:0]       wval,
    input  logic [SEGN_W-1:0] rnum,
    output sel_t              rsel
);

    logic [15:0] sel_q [NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[i] <= '0;
            else if (we && wnum == SEGN_W'(i))
                sel_q[i] <= wval;
        end
    end

    always_comb begin
        rsel = '0;
        for (int i = 0; i < NUM_SEG; i++)
            if (rnum == SEGN_W'(i))
                rsel = sel_t'(sel_q[i]);
    end

endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlat_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [SEL_IDX_W-1:0] widx,
    input  desc_t                wdata,
    input  logic [SEL_IDX_W-1:0] ridx,
    output desc_t                rdata,
    output logic                 rhit
);

    desc_t mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && widx == SEL_IDX_W'(i))
                mem[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        rhit  = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (ridx == SEL_IDX_W'(i)) begin
                rdata = mem[i];
                rhit  = 1'b1;
            end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  sel_t        sel,
    input  desc_t       dsc,
    input  logic        dsc_hit,
    input  logic [31:0] off,
    input  logic [1:0]  acc,
    input  logic [1:0]  cpl,
    output fault_e      fault
);

    logic is_null, bad_priv, bad_limit, bad_type;

    always_comb begin
        is_null   = (sel.index == '0) && !sel.use_local;
        bad_priv  = lvl_max(cpl, sel.rpl) > dsc.dpl;
        bad_limit = off > eff_limit(dsc);
        unique case (acc_e'(acc))
            ACC_WRITE: bad_type = !dsc.wr_ok;
            ACC_FETCH: bad_type = !dsc.ex_ok;
            default:   bad_type = 1'b0;
        endcase

        if (is_null)        fault = FLT_NULL;
        else if (!dsc_hit)  fault = FLT_RANGE;
        else if (bad_priv)  fault = FLT_PRIV;
        else if (bad_limit) fault = FLT_LIMIT;
        else if (bad_type)  fault = FLT_TYPE;
        else                fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int GDT_N   = 8,
    parameter int LDT_N   = 4,
    localparam int SEGN_W = $clog2(NUM_SEG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_we,
    input  logic [SEGN_W-1:0]    sel_wnum,
    input  logic [15:0]          sel_wval,
    input  logic                 dsc_we,
    input  logic                 dsc_local,
    input  logic [SEL_IDX_W-1:0] dsc_widx,
    input  logic [31:0]          dsc_base,
    input  logic [19:0]          dsc_limit,
    input  logic                 dsc_gran,
    input  logic [1:0]           dsc_dpl,
    input  logic                 dsc_wrok,
    input  logic                 dsc_exok,
    input  logic                 req_valid,
    input  logic [SEGN_W-1:0]    req_seg,
    input  logic [31:0]          req_off,
    input  logic [1:0]           req_acc,
    input  logic [1:0]           req_cpl,
    output logic                 out_valid,
    output logic [31:0]          out_lin,
    output logic [2:0]           out_fault
);

    sel_t   cur_sel;
    desc_t  wr_desc, g_desc, l_desc, use_desc;
    logic   g_hit, l_hit, use_hit;
    fault_e chk_fault;

    assign wr_desc = '{base: dsc_base, limit: dsc_limit, gran: dsc_gran,
                       dpl: dsc_dpl, wr_ok: dsc_wrok, ex_ok: dsc_exok};

    seg_sel_bank #(.NUM_SEG(NUM_SEG), .SEGN_W(SEGN_W)) u_sel (
        .clk(clk), .rst(rst), .we(sel_we), .wnum(sel_wnum), .wval(sel_wval),
        .rnum(req_seg), .rsel(cur_sel)
    );

    seg_desc_table #(.DEPTH(GDT_N)) u_gtab (
        .clk(clk), .rst(rst), .we(dsc_we && !dsc_local), .widx(dsc_widx),
        .wdata(wr_desc), .ridx(cur_sel.index), .rdata(g_desc), .rhit(g_hit)
    );

    seg_desc_table #(.DEPTH(LDT_N)) u_ltab (
        .clk(clk), .rst(rst), .we(dsc_we && dsc_local), .widx(dsc_widx),
        .wdata(wr_desc), .ridx(cur_sel.index), .rdata(l_desc), .rhit(l_hit)
    );

    assign use_desc = cur_sel.use_local ? l_desc : g_desc;
    assign use_hit  = cur_sel.use_local ? l_hit  : g_hit;

    seg_check u_chk (
        .sel(cur_sel), .dsc(use_desc), .dsc_hit(use_hit), .off(req_off),
        .acc(req_acc), .cpl(req_cpl), .fault(chk_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_lin   <= '0;
            out_fault <= FLT_NONE;
        end else begin
            out_valid <= req_valid;
            out_fault <= req_valid ? chk_fault : FLT_NONE;
            out_lin   <= (req_valid && chk_fault == FLT_NONE) ? use_desc.base + req_off : '0;
        end
    end

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);                                             // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_fault == 3'd0 && out_lin == 32'd0));              // R3
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault != 3'd0) |-> out_lin == 32'd0);               // R10
    AST_NULL_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_sel.index == '0 && !cur_sel.use_local) |=> out_fault == 3'd1); // R4
    AST_RING_OK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && use_hit && chk_fault == FLT_NONE)
            |-> lvl_max(req_cpl, cur_sel.rpl) <= use_desc.dpl);              // R6
    AST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && chk_fault == FLT_NONE) |-> req_off <= eff_limit(use_desc)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !out_valid);                                                  // R11

endmodule

// File: tb/sim_seg_xlat_top.sv
`timescale 1ns/100ps
module sim_seg_xlat_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_we;
    logic [2:0]  sel_wnum;
    logic [15:0] sel_wval;
    logic        dsc_we, dsc_local;
    logic [12:0] dsc_widx;
    logic [31:0] dsc_base;
    logic [19:0] dsc_limit;
    logic        dsc_gran;
    logic [1:0]  dsc_dpl;
    logic        dsc_wrok, dsc_exok;
    logic        req_valid;
    logic [2:0]  req_seg;
    logic [31:0] req_off;
    logic [1:0]  req_acc, req_cpl;
    logic        out_valid;
    logic [31:0] out_lin;
    logic [2:0]  out_fault;

    always #2.5 clk = ~clk;

    seg_xlat_top u0 (.*);

    int checks = 0;
    int errors = 0;

    // reference state built from the requirements
    logic [15:0] m_sel [6];
    logic [31:0] mg_base [8], ml_base [4];
    logic [19:0] mg_lim  [8], ml_lim  [4];
    logic        mg_gr   [8], ml_gr   [4];
    logic [1:0]  mg_dpl  [8], ml_dpl  [4];
    logic        mg_wr   [8], ml_wr   [4];
    logic        mg_ex   [8], ml_ex   [4];

    logic [31:0] q_lin [$];
    logic [2:0]  q_flt [$];
    string       q_tag [$];

    task automatic check(input bit ok, input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        sel_we = 0; dsc_we = 0; req_valid = 0;
        @(negedge clk);
    endtask

    task automatic wsel(input int n, input logic [15:0] v);
        sel_we = 1; sel_wnum = 3'(n); sel_wval = v;
        if (n < 6) m_sel[n] = v;
        @(negedge clk);
        sel_we = 0;
    endtask

    task automatic wdsc(input bit loc, input int idx, input logic [31:0] b, input logic [19:0] l,
                        input bit g, input logic [1:0] d, input bit w, input bit x);
        dsc_we = 1; dsc_local = loc; dsc_widx = 13'(idx);
        dsc_base = b; dsc_limit = l; dsc_gran = g; dsc_dpl = d; dsc_wrok = w; dsc_exok = x;
        if (!loc && idx < 8) begin
            mg_base[idx] = b; mg_lim[idx] = l; mg_gr[idx] = g; mg_dpl[idx] = d; mg_wr[idx] = w; mg_ex[idx] = x;
        end
        if (loc && idx < 4) begin
            ml_base[idx] = b; ml_lim[idx] = l; ml_gr[idx] = g; ml_dpl[idx] = d; ml_wr[idx] = w; ml_ex[idx] = x;
        end
        @(negedge clk);
        dsc_we = 0;
    endtask

    // driver: computes the expected result and pushes it to the scoreboard
    task automatic req(input int seg, input logic [31:0] off, input logic [1:0] acc,
                       input logic [1:0] cpl, input string tag);
        logic [15:0] s;
        int idx; bit loc, hit;
        logic [31:0] b, lim; logic [1:0] d, rl, eff; bit w, x, badt;
        logic [2:0] f;
        s = (seg < 6) ? m_sel[seg] : 16'h0;
        idx = int'(s[15:3]); loc = s[2]; rl = s[1:0];
        hit = loc ? (idx < 4) : (idx < 8);
        b = 0; lim = 0; d = 0; w = 0; x = 0;
        if (hit && loc) begin
            b = ml_base[idx]; lim = ml_gr[idx] ? {ml_lim[idx], 12'hFFF} : {12'h0, ml_lim[idx]};
            d = ml_dpl[idx]; w = ml_wr[idx]; x = ml_ex[idx];
        end else if (hit) begin
            b = mg_base[idx]; lim = mg_gr[idx] ? {mg_lim[idx], 12'hFFF} : {12'h0, mg_lim[idx]};
            d = mg_dpl[idx]; w = mg_wr[idx]; x = mg_ex[idx];
        end
        eff = (cpl > rl) ? cpl : rl;
        badt = (acc == 2'd1 && !w) || (acc == 2'd2 && !x);
        if (idx == 0 && !loc) f = 3'd1;
        else if (!hit)        f = 3'd2;
        else if (eff > d)     f = 3'd3;
        else if (off > lim)   f = 3'd4;
        else if (badt)        f = 3'd5;
        else                  f = 3'd0;
        q_lin.push_back(f == 0 ? b + off : 32'h0);
        q_flt.push_back(f);
        q_tag.push_back(tag);
        req_valid = 1; req_seg = 3'(seg); req_off = off; req_acc = acc; req_cpl = cpl;
        @(negedge clk);
        req_valid = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_flt.size() == 0) begin
                check(0, "R3 unexpected result", {out_fault, out_lin}, 35'h0);
            end else begin
                logic [31:0] el; logic [2:0] ef; string t;
                el = q_lin.pop_front(); ef = q_flt.pop_front(); t = q_tag.pop_front();
                check(out_lin == el && out_fault == ef, t, {out_fault, out_lin}, {ef, el});
            end
        end
    end

    bit done = 0;
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m_sel[i] = 0;
        for (int i = 0; i < 8; i++) begin
            mg_base[i] = 0; mg_lim[i] = 0; mg_gr[i] = 0; mg_dpl[i] = 0; mg_wr[i] = 0; mg_ex[i] = 0;
        end
        for (int i = 0; i < 4; i++) begin
            ml_base[i] = 0; ml_lim[i] = 0; ml_gr[i] = 0; ml_dpl[i] = 0; ml_wr[i] = 0; ml_ex[i] = 0;
        end
        rst = 1; sel_we = 0; sel_wnum = 0; sel_wval = 0; dsc_we = 0; dsc_local = 0; dsc_widx = 0;
        dsc_base = 0; dsc_limit = 0; dsc_gran = 0; dsc_dpl = 0; dsc_wrok = 0; dsc_exok = 0;
        req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0; req_cpl = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        check(out_valid == 0, "R11 valid low after reset", {34'h0, out_valid}, 35'h0);
        req(1, 32'h10, 2'd0, 2'd0, "R11 selectors zero gives null");

        // shared table entries
        wdsc(0, 1, 32'h1000_0000, 20'hFFFFF, 1, 2'd3, 1, 1);
        wdsc(0, 2, 32'hFFFF_F000, 20'hFFFFF, 1, 2'd3, 1, 1);
        wdsc(0, 3, 32'h0000_0000, 20'h00002, 1, 2'd3, 1, 0);
        wdsc(0, 9, 32'h7000_0000, 20'hFFFFF, 1, 2'd3, 1, 1);   // beyond depth, ignored
        // per-task table entries
        wdsc(1, 0, 32'h4000_0000, 20'h00FFF, 0, 2'd2, 1, 0);
        wdsc(1, 1, 32'h5000_0000, 20'h000FF, 0, 2'd3, 0, 1);
        wdsc(1, 5, 32'h6000_0000, 20'hFFFFF, 1, 2'd3, 1, 1);   // beyond depth, ignored

        wsel(0, 16'h0008);  // shared 1, rpl0
        wsel(1, 16'h0010);  // shared 2
        wsel(2, 16'h0004);  // local 0, rpl0
        wsel(3, 16'h000C);  // local 1
        wsel(4, 16'h0018);  // shared 3
        wsel(5, 16'h0048);  // shared 9
        wsel(7, 16'h0008);  // ignored
        idle();

        req(0, 32'h0000_1234, 2'd0, 2'd0, "R3 base plus offset");
        req(1, 32'h0000_2000, 2'd0, 2'd0, "R3 sum wraps");
        req(0, 32'hABCD_0000, 2'd1, 2'd3, "R3 back to back write");
        req(3, 32'h0000_0010, 2'd2, 2'd0, "R2 local index 1");
        req(2, 32'h0000_0FFF, 2'd1, 2'd0, "R4 local index 0 not null");
        req(2, 32'h0000_1000, 2'd0, 2'd0, "R7 byte limit exceeded");
        req(4, 32'h0000_2FFF, 2'd0, 2'd0, "R8 page limit top");
        req(4, 32'h0000_3000, 2'd0, 2'd0, "R8 page limit exceeded");
        req(2, 32'h0000_0000, 2'd0, 2'd3, "R6 outer ring refused");
        req(2, 32'h0000_0100, 2'd0, 2'd2, "R6 equal ring allowed");
        req(2, 32'h0000_0000, 2'd2, 2'd0, "R9 fetch without exec");
        req(3, 32'h0000_0000, 2'd1, 2'd0, "R9 write without write");
        req(3, 32'h0000_0000, 2'd3, 2'd0, "R9 read code 3 no type fault");
        req(5, 32'h0000_0000, 2'd0, 2'd0, "R5 shared index beyond depth");
        req(6, 32'h0000_0000, 2'd0, 2'd0, "R1 register 6 reads zero");
        req(7, 32'h0000_0000, 2'd0, 2'd0, "R1 register 7 write ignored");
        req(2, 32'h0000_5000, 2'd0, 2'd3, "R10 priv beats limit");
        req(3, 32'h0000_1000, 2'd1, 2'd0, "R10 limit beats type");
        idle();

        wsel(2, 16'h0006);  // local 0, rpl2
        wsel(3, 16'h0024);  // local 4 beyond depth
        wsel(5, 16'h0007);  // local 0, rpl3
        idle();
        req(2, 32'h0000_0020, 2'd0, 2'd0, "R6 requested level 2 allowed");
        req(5, 32'h0000_0020, 2'd0, 2'd0, "R6 requested level 3 refused");
        req(3, 32'h0000_0000, 2'd0, 2'd0, "R5 local index beyond depth");
        idle(); idle(); idle();
        check(q_flt.size() == 0, "R3 all results returned", 35'(q_flt.size()), 35'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule